// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block is a purely combinational bit-field engine for a word-wide datapath. It either pulls a field out of a source word and returns it right-justified, or merges a field into a destination word. The field is described by a start position and a length. Two extract flavours are offered. The zero-fill flavour clears every bit above the field. The sign-fill flavour copies the field's highest bit into every bit above the field.

The insert operation takes the low bits of the source word and places them at the start position of the destination word. All destination bits outside the field keep their value. A field that would run past the top bit of the word is cut off at the top bit. A zero-length field yields zero for extracts and the untouched destination word for insert. The unit sits between register read and write-back, and its result is valid in the same cycle as its inputs.

Top module: `bfu_top`

## Requirements
- R1: With `op_sel` = 0 (zero-fill extract), `result` holds bits `fld_start` .. `fld_start`+n-1 of `src_word` in bits 0 .. n-1, and zeros in every bit from n upward. Here n is the effective length defined in R5.
- R2: With `op_sel` = 1 (sign-fill extract), `result` bits 0 .. n-1 hold the same field as in R1. Every bit from n upward equals `src_word` bit `fld_start`+n-1.
- R3: With `op_sel` = 2 (insert), `result` bits `fld_start` .. `fld_start`+n-1 hold bits 0 .. n-1 of `src_word`.
- R4: With `op_sel` = 2, every `result` bit outside `fld_start` .. `fld_start`+n-1 equals the same bit of `dst_word`.
- R5: The effective length n is the smaller of `fld_len` and 32 − `fld_start`. A field therefore never extends past bit 31. This covers `fld_len` values from 33 to 63.
- R6: When n = 0, `result` is 0 for both extracts, and `result` equals `dst_word` for insert.
- R7: `op_sel` = 3 is reserved. `result` then equals `dst_word`, whatever the other inputs are.
- R8: The unit has no storage. `result` follows any input change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 0 zero-fill extract, 1 sign-fill extract, 2 insert, 3 reserved |
| src_word | input | 32 | Word the field is taken from (extract) or whose low bits are inserted (insert) |
| dst_word | input | 32 | Current destination word; the base that insert merges into |
| fld_start | input | 5 | Bit position of the field's lowest bit |
| fld_len | input | 6 | Requested field length, 0 to 63, clipped per R5 |
| result | output | 32 | New destination value |

## Verification
The unit holds no state, so an internal fault shows up directly on `result` for the same input vector. A wrong length clip or a misbuilt field mask first shows in the bits adjacent to the field edge. These are stray ones above an extracted field, a sign bit taken from the wrong position, or a destination bit overwritten just outside an inserted field. The directed vectors sit fields against bit 0, against bit 31 and across the clip boundary, so an off-by-one in the mask or the shifter changes a checked bit on the first vector that exercises that edge.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic [1:0] {
      BFU_EXT_ZERO = 2'd0,
      BFU_EXT_SIGN = 2'd1,
      BFU_INSERT   = 2'd2,
      BFU_RESERVED = 2'd3
   } bfu_op_e;

   // shifter implementation choices
   localparam int BFU_SHIFT_NATIVE = 0;
   localparam int BFU_SHIFT_STAGED = 1;

endpackage

// File: rtl/bfu_shift.sv
module bfu_shift #(
   parameter int W        = 32,
   parameter int AMT_W    = $clog2(W),
   parameter bit LEFT     = 1'b0,
   parameter int IMPL     = bfu_pkg::BFU_SHIFT_STAGED
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     dout
);

   if (AMT_W < 1 || (1 << AMT_W) < W) begin : g_bad_amt
      $error("bfu_shift: AMT_W too small for W");
   end

   if (IMPL == bfu_pkg::BFU_SHIFT_NATIVE) begin : g_native
      if (LEFT) begin : g_l
         assign dout = din << amt;
      end else begin : g_r
         assign dout = din >> amt;
      end
   end else begin : g_staged
      logic [W-1:0] stg [0:AMT_W];
      assign stg[0] = din;
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         if (LEFT) begin : g_l
            assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
         end else begin : g_r
            assign stg[s+1] = amt[s] ? (stg[s] >> (1 << s)) : stg[s];
         end
      end
      assign dout = stg[AMT_W];
   end

endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
   parameter int W     = 32,
   parameter int POS_W = $clog2(W),
   parameter int LEN_W = POS_W + 1,
   parameter int IMPL  = bfu_pkg::BFU_SHIFT_STAGED
) (
   input  logic [POS_W-1:0] start,
   input  logic [LEN_W-1:0] len_req,
   output logic [LEN_W-1:0] len_eff,
   output logic [W-1:0]     low_mask,
   output logic [W-1:0]     field_mask
);

   localparam logic [LEN_W-1:0] FULL = LEN_W'(W);

   logic [LEN_W-1:0] room;

   // space between the start position and the top of the word
   assign room    = FULL - {1'b0, start};
   assign len_eff = (len_req > room) ? room : len_req;

   // thermometer code: bit k is set while k is below the effective length
   for (genvar k = 0; k < W; k++) begin : g_therm
      assign low_mask[k] = (LEN_W'(k) < len_eff);
   end

   bfu_shift #(
      .W(W), .AMT_W(POS_W), .LEFT(1'b1), .IMPL(IMPL)
   ) u_place (
      .din(low_mask), .amt(start), .dout(field_mask)
   );

   always_comb begin
      AST_MASK_LEN: assert ($countones(low_mask) == int'(len_eff)) // R5
         else $error("low mask population differs from clipped length");
      AST_CLIP_BOUND: assert ((int'(len_eff) + int'(start) <= W) && (len_eff <= len_req)) // R5
         else $error("clipped field runs past the word");
   end

endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
   parameter int W     = 32,
   parameter int POS_W = $clog2(W),
   parameter int LEN_W = POS_W + 1,
   parameter int IMPL  = bfu_pkg::BFU_SHIFT_STAGED
) (
   input  logic [W-1:0]     src,
   input  logic [POS_W-1:0] start,
   input  logic [LEN_W-1:0] len_eff,
   input  logic [W-1:0]     low_mask,
   input  logic             sign_fill,
   output logic [W-1:0]     dout
);

   logic [W-1:0]     aligned;
   logic [W-1:0]     zfield;
   logic [POS_W-1:0] top_idx;
   logic             top_bit;

   bfu_shift #(
      .W(W), .AMT_W(POS_W), .LEFT(1'b0), .IMPL(IMPL)
   ) u_align (
      .din(src), .amt(start), .dout(aligned)
   );

   assign zfield = aligned & low_mask;
   // a full-width field wraps to index W-1, which is its correct top bit
   assign top_idx = len_eff[POS_W-1:0] - POS_W'(1);
   assign top_bit = (len_eff != '0) & aligned[top_idx];

   always_comb begin
      if (sign_fill) dout = zfield | (~low_mask & {W{top_bit}});
      else           dout = zfield;
   end

   always_comb begin
      AST_ZERO_LEN_EXT: assert ((len_eff != '0) || (dout == '0)) // R6
         else $error("empty field extract is not zero");
      AST_FIELD_KEEP: assert ((dout & low_mask) == ((src >> start) & low_mask)) // R1
         else $error("extracted field bits differ from source");
   end

endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
   parameter int W     = 32,
   parameter int POS_W = $clog2(W),
   parameter int IMPL  = bfu_pkg::BFU_SHIFT_STAGED
) (
   input  logic [W-1:0]     src,
   input  logic [W-1:0]     base,
   input  logic [POS_W-1:0] start,
   input  logic [W-1:0]     field_mask,
   output logic [W-1:0]     dout
);

   logic [W-1:0] placed;

   bfu_shift #(
      .W(W), .AMT_W(POS_W), .LEFT(1'b1), .IMPL(IMPL)
   ) u_place (
      .din(src), .amt(start), .dout(placed)
   );

   assign dout = (base & ~field_mask) | (placed & field_mask);

   always_comb begin
      AST_INS_OUTSIDE: assert (((dout ^ base) & ~field_mask) == '0) // R4
         else $error("insert disturbed a bit outside the field");
   end

endmodule

// File: rtl/bfu_top.sv
module bfu_top #(
   parameter int W     = 32,
   parameter int IMPL  = bfu_pkg::BFU_SHIFT_STAGED,
   parameter int POS_W = $clog2(W),
   parameter int LEN_W = POS_W + 1
) (
   input  logic [1:0]       op_sel,
   input  logic [W-1:0]     src_word,
   input  logic [W-1:0]     dst_word,
   input  logic [POS_W-1:0] fld_start,
   input  logic [LEN_W-1:0] fld_len,
   output logic [W-1:0]     result
);
   import bfu_pkg::*;

   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("bfu_top: W must be a power of two of at least 2");
   end
   if (IMPL != BFU_SHIFT_NATIVE && IMPL != BFU_SHIFT_STAGED) begin : g_bad_impl
      $error("bfu_top: unknown shifter implementation");
   end

   bfu_op_e          op;
   logic [LEN_W-1:0] len_eff;
   logic [W-1:0]     low_mask;
   logic [W-1:0]     field_mask;
   logic [W-1:0]     ext_out;
   logic [W-1:0]     ins_out;

   assign op = bfu_op_e'(op_sel);

   bfu_mask_gen #(.W(W), .POS_W(POS_W), .LEN_W(LEN_W), .IMPL(IMPL)) u_mask (
      .start(fld_start), .len_req(fld_len), .len_eff(len_eff),
      .low_mask(low_mask), .field_mask(field_mask)
   );

   bfu_extract #(.W(W), .POS_W(POS_W), .LEN_W(LEN_W), .IMPL(IMPL)) u_ext (
      .src(src_word), .start(fld_start), .len_eff(len_eff),
      .low_mask(low_mask), .sign_fill(op == BFU_EXT_SIGN), .dout(ext_out)
   );

   bfu_insert #(.W(W), .POS_W(POS_W), .IMPL(IMPL)) u_ins (
      .src(src_word), .base(dst_word), .start(fld_start),
      .field_mask(field_mask), .dout(ins_out)
   );

   always_comb begin
      unique case (op)
         BFU_EXT_ZERO, BFU_EXT_SIGN: result = ext_out;
         BFU_INSERT:                 result = ins_out;
         default:                    result = dst_word;
      endcase
   end

   always_comb begin
      AST_EXTZ_HIGH_CLEAR: assert ((op != BFU_EXT_ZERO) || ((result & ~low_mask) == '0)) // R1
         else $error("zero-fill extract left bits above the field");
      AST_EXTS_UNIFORM: assert ((op != BFU_EXT_SIGN) || ((result & ~low_mask) == '0)
                                || ((result | low_mask) == '1)) // R2
         else $error("sign-fill extract has mixed bits above the field");
      AST_RSV_PASS: assert ((op != BFU_RESERVED) || (result == dst_word)) // R7
         else $error("reserved operation altered the destination");
      AST_INS_EMPTY: assert ((op != BFU_INSERT) || (len_eff != '0) || (result == dst_word)) // R6
         else $error("empty insert changed the destination");
   end

endmodule

// File: tb/tb_bfu_top.sv
module tb_bfu_top;

   logic        clk = 1'b0;
   logic [1:0]  op_sel;
   logic [31:0] src_word, dst_word, result;
   logic [4:0]  fld_start;
   logic [5:0]  fld_len;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   bfu_top dut (
      .op_sel(op_sel), .src_word(src_word), .dst_word(dst_word),
      .fld_start(fld_start), .fld_len(fld_len), .result(result)
   );

   // reference: field mask from a right-shifted all-ones word
   function automatic logic [31:0] ref_model(input logic [1:0] op, input logic [31:0] ra,
                                             input logic [31:0] rt, input int i, input int l);
      int n;
      logic [31:0] ones, low, fld;
      n    = (l < 32 - i) ? l : 32 - i;
      ones = '1;
      low  = (n == 0) ? 32'h0 : (ones >> (32 - n));
      fld  = (ra >> i) & low;
      case (op)
         2'd0: return fld;
         2'd1: return (n == 0) ? 32'h0 : (ra[i+n-1] ? (fld | ~low) : fld);
         2'd2: return (rt & ~(low << i)) | ((ra << i) & (low << i));
         default: return rt;
      endcase
   endfunction

   task automatic apply(input logic [1:0] op, input logic [31:0] ra, input logic [31:0] rt,
                        input int i, input int l);
      @(posedge clk);
      op_sel = op; src_word = ra; dst_word = rt;
      fld_start = 5'(i); fld_len = 6'(l);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] exp);
      n_checks++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s: op=%0d start=%0d len=%0d actual=%08h expected=%08h",
                  tag, op_sel, fld_start, fld_len, result, exp);
      end
   endtask

   task automatic run(input string tag, input logic [1:0] op, input logic [31:0] ra,
                      input logic [31:0] rt, input int i, input int l, input logic [31:0] exp);
      apply(op, ra, rt, i, l);
      check(tag, exp);
   endtask

   task automatic t_idle;
      run("R1 all-zero inputs", 2'd0, 32'h0, 32'h0, 0, 0, 32'h0);
   endtask

   task automatic t_extract_zero;
      run("R1 mid field",  2'd0, 32'hDEAD_BEEF, 32'h0, 8, 8, 32'h0000_00BE);
      run("R1 low field",  2'd0, 32'hFFFF_FFFF, 32'h0, 0, 4, 32'h0000_000F);
      run("R1 full word",  2'd0, 32'h8765_4321, 32'h0, 0, 32, 32'h8765_4321);
   endtask

   task automatic t_extract_sign;
      run("R2 negative field", 2'd1, 32'h0000_0F00, 32'h0, 8, 4, 32'hFFFF_FFFF);
      run("R2 positive field", 2'd1, 32'h0000_0700, 32'h0, 8, 4, 32'h0000_0007);
      run("R2 top bit one",    2'd1, 32'h8000_0000, 32'h0, 31, 1, 32'hFFFF_FFFF);
   endtask

   task automatic t_insert;
      run("R3 nibble in middle", 2'd2, 32'h0000_000A, 32'h1234_5678, 12, 4, 32'h1234_A678);
      run("R3 top byte",         2'd2, 32'hFFFF_FF5C, 32'h0000_0000, 24, 8, 32'h5C00_0000);
      run("R4 ones kept",        2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 4, 3, 32'hFFFF_FF8F);
   endtask

   task automatic t_clip;
      run("R5 extract clipped",   2'd0, 32'hF000_0000, 32'h0, 28, 10, 32'h0000_000F);
      run("R5 len 63 at 0",       2'd1, 32'h7FFF_FFFF, 32'h0, 0, 63, 32'h7FFF_FFFF);
      run("R5 insert clipped",    2'd2, 32'h0000_00FF, 32'h0000_0000, 30, 8, 32'hC000_0000);
   endtask

   task automatic t_empty;
      run("R6 empty zero-fill", 2'd0, 32'hFFFF_FFFF, 32'h1111_1111, 5, 0, 32'h0);
      run("R6 empty sign-fill", 2'd1, 32'hFFFF_FFFF, 32'h1111_1111, 5, 0, 32'h0);
      run("R6 empty insert",    2'd2, 32'hFFFF_FFFF, 32'h1357_9BDF, 5, 0, 32'h1357_9BDF);
   endtask

   task automatic t_reserved;
      run("R7 reserved op",  2'd3, 32'hFFFF_FFFF, 32'hCAFE_F00D, 0, 32, 32'hCAFE_F00D);
      run("R7 reserved op2", 2'd3, 32'h0000_0000, 32'h0BAD_CAFE, 17, 9, 32'h0BAD_CAFE);
   endtask

   task automatic t_comb;
      // R8: change inputs mid-cycle and sample before the next edge
      apply(2'd0, 32'h0000_FF00, 32'h0, 8, 8);
      #1 fld_start = 5'd12;
      #1 check("R8 follows input without clock", 32'h0000_000F);
   endtask

   task automatic t_random;
      for (int k = 0; k < 3000; k++) begin
         logic [1:0]  op;
         logic [31:0] ra, rt;
         int i, l;
         op = 2'($urandom_range(0, 3));
         ra = $urandom; rt = $urandom;
         i  = $urandom_range(0, 31);
         l  = $urandom_range(0, 63);
         apply(op, ra, rt, i, l);
         case (op)
            2'd0: check("R1 random", ref_model(op, ra, rt, i, l));
            2'd1: check("R2 random", ref_model(op, ra, rt, i, l));
            2'd2: check("R3 random", ref_model(op, ra, rt, i, l));
            default: check("R7 random", ref_model(op, ra, rt, i, l));
         endcase
      end
   endtask

   initial begin
      op_sel = 2'd0; src_word = '0; dst_word = '0; fld_start = '0; fld_len = '0;
      repeat (2) @(posedge clk);
      t_idle();
      t_extract_zero();
      t_extract_sign();
      t_insert();
      t_clip();
      t_empty();
      t_reserved();
      t_comb();
      t_random();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule